// File: doc/BRIEF.md
# Link Speed and Duplex Resolver

This block settles the operating speed and duplex of an Ethernet MAC once autonegotiation has finished. When started, it fetches two words from the PHY through a simple request/acknowledge management-read port. The first is the local advertisement register and the second is the link-partner ability register. It keeps only the abilities both ends share, picks the best of them by a fixed priority, and presents the result to the MAC. The result is a forced link-speed word plus a full-duplex flag.

A resolution begins on a one-cycle trigger or on a link-change event. Each resolution ends with a one-cycle done pulse. A change pulse appears alongside done only when the resolved speed or duplex differs from the value already held. A read that comes back with an error ends the attempt early, and the held result stays in force. Serial bit timing towards the PHY belongs to a separate management block.

Top module: `link_resolver`

## Requirements
- R1: A resolution issues exactly two reads in this order: register address 4 (advertisement), then register address 5 (partner ability). `mgmt_req_o` stays high with `mgmt_reg_o` and `mgmt_phy_o` stable until an acknowledge cycle. `mgmt_phy_o` carries the PHY address captured when the resolution started.
- R2: The resolution uses the bitwise AND of the two words. Bit 8 set gives 100 Mb/s full duplex. Otherwise bit 7 gives 100 Mb/s half. Otherwise bit 6 gives 10 Mb/s full. Otherwise bit 5 gives 10 Mb/s half.
- R3: When none of bits 8..5 is set in the AND, the result is 10 Mb/s half duplex.
- R4: `speed_word_o` is bit 16 (force) ORed with decimal 10 (0x1000A) or decimal 100 (0x10064). `full_duplex_o` is 1 for full and 0 for half.
- R5: `changed_o` pulses for one cycle only when the new speed or duplex differs from the held value. In that same cycle the outputs show the new value. In every other cycle the outputs hold.
- R6: After reset the outputs are 0x1000A and half duplex, with no request, no done and no change pulse.
- R7: A read acknowledged with `mgmt_err_i` high abandons the resolution. Done pulses on the next cycle, the outputs are left as they were, and no read of address 5 follows a failed read of address 4.
- R8: `done_o` pulses for one cycle at the end of every resolution. On success this is two cycles after the acknowledge of the second read, and the outputs update in that same cycle.
- R9: Either `start_i` or `link_event_i` begins a resolution while the block is idle. Triggers that arrive while a resolution is in progress are ignored and produce no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Trigger pulse for a resolution |
| link_event_i | input | 1 | Link-change event, also starts a resolution |
| phy_addr_i | input | 5 | Address of the PHY to query |
| mgmt_req_o | output | 1 | Management read request, held until acknowledged |
| mgmt_phy_o | output | 5 | PHY address of the pending read |
| mgmt_reg_o | output | 5 | Register address of the pending read |
| mgmt_ack_i | input | 1 | One-cycle acknowledge of the pending read |
| mgmt_rdata_i | input | 16 | Read data, valid with the acknowledge |
| mgmt_err_i | input | 1 | Read failed, valid with the acknowledge |
| speed_word_o | output | 32 | Forced link-speed word for the MAC |
| full_duplex_o | output | 1 | 1 for full duplex |
| changed_o | output | 1 | Pulse: result differs from the previous one |
| done_o | output | 1 | Pulse: resolution finished or abandoned |

## Verification
The bench builds the block with its default parameters: 16-bit read data, 5-bit register and PHY addresses, advertisement at 4, partner ability at 5, a 32-bit speed word and the force flag at bit 16. Its PHY model answers after three cycles of held request. Because of that delay, a trigger can land while a read is pending, and the stability of the request fields over several cycles can be observed. The ability pairs are chosen so that each priority level and the fallback are reached, including cases where the AND removes a bit only one side offers. Errors are injected on each of the two reads.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ADV    = 2'd1,
    SEQ_LPA    = 2'd2,
    SEQ_COMMIT = 2'd3
  } seq_state_t;

  // ability bit positions in the shared management words
  localparam int ABIL_100_FULL = 8;
  localparam int ABIL_100_HALF = 7;
  localparam int ABIL_10_FULL  = 6;
  localparam int ABIL_10_HALF  = 5;

  localparam int RATE_SLOW = 10;
  localparam int RATE_FAST = 100;

  typedef struct packed {
    logic fast;
    logic full;
  } link_mode_t;
endpackage

// File: rtl/lsr_seq.sv
module lsr_seq
  import lsr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_AW   = 5,
  parameter int PHY_AW   = 5,
  parameter int ADV_ADDR = 4,
  parameter int LPA_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              err_i,
  output logic              req_o,
  output logic [PHY_AW-1:0] phy_o,
  output logic [REG_AW-1:0] reg_o,
  output logic [DATA_W-1:0] adv_o,
  output logic [DATA_W-1:0] lpa_o,
  output logic              commit_o,
  output logic              abort_o
);
  localparam logic [REG_AW-1:0] ADV_A = REG_AW'(ADV_ADDR);
  localparam logic [REG_AW-1:0] LPA_A = REG_AW'(LPA_ADDR);

  seq_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      phy_o   <= '0;
      adv_o   <= '0;
      lpa_o   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (trig_i) begin
            state_q <= SEQ_ADV;
            phy_o   <= phy_addr_i;
          end
        end
        SEQ_ADV: begin
          if (ack_i) begin
            if (err_i) begin
              state_q <= SEQ_IDLE;
            end else begin
              adv_o   <= rdata_i;
              state_q <= SEQ_LPA;
            end
          end
        end
        SEQ_LPA: begin
          if (ack_i) begin
            if (err_i) begin
              state_q <= SEQ_IDLE;
            end else begin
              lpa_o   <= rdata_i;
              state_q <= SEQ_COMMIT;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    req_o    = (state_q == SEQ_ADV) || (state_q == SEQ_LPA);
    reg_o    = (state_q == SEQ_LPA) ? LPA_A : ADV_A;
    commit_o = (state_q == SEQ_COMMIT);
    abort_o  = req_o && ack_i && err_i;
  end
endmodule

// File: rtl/lsr_decide.sv
module lsr_decide
  import lsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] adv_i,
  input  logic [DATA_W-1:0] lpa_i,
  output link_mode_t        mode_o
);
  logic [DATA_W-1:0] common;
  logic              unused_bits;

  assign common      = adv_i & lpa_i;
  assign unused_bits = ^common;

  always_comb begin
    if (common[ABIL_100_FULL]) begin
      mode_o = '{fast: 1'b1, full: 1'b1};
    end else if (common[ABIL_100_HALF]) begin
      mode_o = '{fast: 1'b1, full: 1'b0};
    end else if (common[ABIL_10_FULL]) begin
      mode_o = '{fast: 1'b0, full: 1'b1};
    end else begin
      // bit 5 alone and the no-match fallback both land on 10 half
      mode_o = '{fast: 1'b0, full: 1'b0};
    end
  end
endmodule

// File: rtl/lsr_state.sv
module lsr_state
  import lsr_pkg::*;
#(
  parameter int SPEED_W   = 32,
  parameter int FORCE_POS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic               abort_i,
  input  link_mode_t         mode_i,
  output logic [SPEED_W-1:0] speed_o,
  output logic               full_o,
  output logic               changed_o,
  output logic               done_o
);
  localparam logic [SPEED_W-1:0] FORCE_FLAG = SPEED_W'(1) << FORCE_POS;
  localparam logic [SPEED_W-1:0] WORD_SLOW  = FORCE_FLAG | SPEED_W'(RATE_SLOW);
  localparam logic [SPEED_W-1:0] WORD_FAST  = FORCE_FLAG | SPEED_W'(RATE_FAST);

  logic [SPEED_W-1:0] next_word;
  logic               differs;

  always_comb begin
    next_word = mode_i.fast ? WORD_FAST : WORD_SLOW;
    differs   = (next_word != speed_o) || (mode_i.full != full_o);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      speed_o   <= WORD_SLOW;
      full_o    <= 1'b0;
      changed_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o    <= commit_i || abort_i;
      changed_o <= commit_i && differs;
      if (commit_i && differs) begin
        speed_o <= next_word;
        full_o  <= mode_i.full;
      end
    end
  end
endmodule

// File: rtl/link_resolver.sv
module link_resolver
  import lsr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REG_AW    = 5,
  parameter int PHY_AW    = 5,
  parameter int ADV_ADDR  = 4,
  parameter int LPA_ADDR  = 5,
  parameter int SPEED_W   = 32,
  parameter int FORCE_POS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               link_event_i,
  input  logic [PHY_AW-1:0]  phy_addr_i,
  output logic               mgmt_req_o,
  output logic [PHY_AW-1:0]  mgmt_phy_o,
  output logic [REG_AW-1:0]  mgmt_reg_o,
  input  logic               mgmt_ack_i,
  input  logic [DATA_W-1:0]  mgmt_rdata_i,
  input  logic               mgmt_err_i,
  output logic [SPEED_W-1:0] speed_word_o,
  output logic               full_duplex_o,
  output logic               changed_o,
  output logic               done_o
);
  logic [DATA_W-1:0] adv_w;
  logic [DATA_W-1:0] lpa_w;
  logic              commit_w;
  logic              abort_w;
  link_mode_t        mode_w;

  lsr_seq #(
    .DATA_W  (DATA_W),
    .REG_AW  (REG_AW),
    .PHY_AW  (PHY_AW),
    .ADV_ADDR(ADV_ADDR),
    .LPA_ADDR(LPA_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trig_i    (start_i | link_event_i),
    .phy_addr_i(phy_addr_i),
    .ack_i     (mgmt_ack_i),
    .rdata_i   (mgmt_rdata_i),
    .err_i     (mgmt_err_i),
    .req_o     (mgmt_req_o),
    .phy_o     (mgmt_phy_o),
    .reg_o     (mgmt_reg_o),
    .adv_o     (adv_w),
    .lpa_o     (lpa_w),
    .commit_o  (commit_w),
    .abort_o   (abort_w)
  );

  lsr_decide #(
    .DATA_W(DATA_W)
  ) u_decide (
    .adv_i (adv_w),
    .lpa_i (lpa_w),
    .mode_o(mode_w)
  );

  lsr_state #(
    .SPEED_W  (SPEED_W),
    .FORCE_POS(FORCE_POS)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit_w),
    .abort_i  (abort_w),
    .mode_i   (mode_w),
    .speed_o  (speed_word_o),
    .full_o   (full_duplex_o),
    .changed_o(changed_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
  parameter int REG_AW    = 5,
  parameter int ADV_ADDR  = 4,
  parameter int LPA_ADDR  = 5,
  parameter int SPEED_W   = 32,
  parameter int FORCE_POS = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mgmt_req_o,
  input logic [REG_AW-1:0]  mgmt_reg_o,
  input logic               mgmt_ack_i,
  input logic               mgmt_err_i,
  input logic [SPEED_W-1:0] speed_word_o,
  input logic               full_duplex_o,
  input logic               changed_o,
  input logic               done_o
);
  localparam logic [SPEED_W-1:0] W_SLOW = (SPEED_W'(1) << FORCE_POS) | SPEED_W'(10);
  localparam logic [SPEED_W-1:0] W_FAST = (SPEED_W'(1) << FORCE_POS) | SPEED_W'(100);
  localparam logic [REG_AW-1:0]  A_ADV  = REG_AW'(ADV_ADDR);
  localparam logic [REG_AW-1:0]  A_LPA  = REG_AW'(LPA_ADDR);

  p_reg_sel_r1: assert property (@(posedge clk) disable iff (rst)
    mgmt_req_o |-> (mgmt_reg_o == A_ADV || mgmt_reg_o == A_LPA));

  p_second_read_r1: assert property (@(posedge clk) disable iff (rst)
    (mgmt_req_o && mgmt_ack_i && !mgmt_err_i && mgmt_reg_o == A_ADV)
      |=> (mgmt_req_o && mgmt_reg_o == A_LPA));

  p_speed_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (speed_word_o == W_SLOW || speed_word_o == W_FAST));

  p_change_differs_r5: assert property (@(posedge clk) disable iff (rst)
    changed_o |-> (speed_word_o != $past(speed_word_o) ||
                   full_duplex_o != $past(full_duplex_o)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !changed_o |-> ($stable(speed_word_o) && $stable(full_duplex_o)));

  p_change_with_done_r5: assert property (@(posedge clk) disable iff (rst)
    changed_o |-> done_o);

  p_err_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (mgmt_req_o && mgmt_ack_i && mgmt_err_i) |=> (done_o && !changed_o && !mgmt_req_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind link_resolver lsr_checker #(
  .REG_AW   (REG_AW),
  .ADV_ADDR (ADV_ADDR),
  .LPA_ADDR (LPA_ADDR),
  .SPEED_W  (SPEED_W),
  .FORCE_POS(FORCE_POS)
) u_lsr_checker (
  .clk          (clk),
  .rst          (rst),
  .mgmt_req_o   (mgmt_req_o),
  .mgmt_reg_o   (mgmt_reg_o),
  .mgmt_ack_i   (mgmt_ack_i),
  .mgmt_err_i   (mgmt_err_i),
  .speed_word_o (speed_word_o),
  .full_duplex_o(full_duplex_o),
  .changed_o    (changed_o),
  .done_o       (done_o)
);

// File: tb/test_link_resolver.sv
module test_link_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int RESP_LAT   = 3;
  localparam logic [31:0] W10  = 32'h0001000A;
  localparam logic [31:0] W100 = 32'h00010064;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st = 1'b0;
  logic        ev = 1'b0;
  logic [4:0]  phy_addr = 5'd3;
  logic        req;
  logic [4:0]  mphy;
  logic [4:0]  mreg;
  logic        ack = 1'b0;
  logic [15:0] rdata = '0;
  logic        err = 1'b0;
  logic [31:0] speed;
  logic        fdx;
  logic        chg;
  logic        done;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_resolver i_link_resolver (
    .clk(clk), .rst(rst), .start_i(st), .link_event_i(ev), .phy_addr_i(phy_addr),
    .mgmt_req_o(req), .mgmt_phy_o(mphy), .mgmt_reg_o(mreg), .mgmt_ack_i(ack),
    .mgmt_rdata_i(rdata), .mgmt_err_i(err), .speed_word_o(speed),
    .full_duplex_o(fdx), .changed_o(chg), .done_o(done)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // PHY register file and responder
  logic [15:0] phy_regs [32];
  int err_reg = -1;
  int cnt = 0;
  int lpa_acks = 0;

  always @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      cnt <= 0;
    end else if (ack) begin
      ack <= 1'b0;
    end else if (req) begin
      if (cnt == RESP_LAT - 1) begin
        ack   <= 1'b1;
        rdata <= phy_regs[mreg];
        err   <= (err_reg == int'(mreg));
        cnt   <= 0;
        if (mreg == 5'd5) lpa_acks <= lpa_acks + 1;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  // behavioural reference model
  int          m_ph = 0;
  logic [15:0] m_adv = '0;
  logic [15:0] m_lpa = '0;
  logic [31:0] m_speed = W10;
  logic        m_fdx = 1'b0;
  logic        m_chg = 1'b0;
  logic        m_done = 1'b0;
  logic [4:0]  m_phy = '0;

  always @(posedge clk) begin
    logic [15:0] c;
    logic        f, d;
    logic [31:0] w;
    if (rst) begin
      m_ph = 0; m_speed = W10; m_fdx = 0; m_chg = 0; m_done = 0;
    end else begin
      m_chg = 0; m_done = 0;
      if (m_ph == 0) begin
        if (st || ev) begin m_ph = 1; m_phy = phy_addr; end
      end else if (m_ph == 1 || m_ph == 2) begin
        if (ack) begin
          if (err) begin m_ph = 0; m_done = 1; end
          else if (m_ph == 1) begin m_adv = rdata; m_ph = 2; end
          else begin m_lpa = rdata; m_ph = 3; end
        end
      end else begin
        c = m_adv & m_lpa;
        if (c[8])      begin f = 1; d = 1; end
        else if (c[7]) begin f = 1; d = 0; end
        else if (c[6]) begin f = 0; d = 1; end
        else           begin f = 0; d = 0; end
        w = f ? W100 : W10;
        if (w != m_speed || d != m_fdx) begin
          m_chg = 1; m_speed = w; m_fdx = d;
        end
        m_done = 1;
        m_ph = 0;
      end
    end
  end

  int done_cnt = 0;
  int chg_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 request", {31'd0, req}, {31'd0, (m_ph == 1 || m_ph == 2)});
      if (req) begin
        chk("R1 register", {27'd0, mreg}, (m_ph == 1) ? 32'd4 : 32'd5);
        chk("R1 phy", {27'd0, mphy}, {27'd0, m_phy});
      end
      chk("R4 speed word", speed, m_speed);
      chk("R2 duplex", {31'd0, fdx}, {31'd0, m_fdx});
      chk("R5 change", {31'd0, chg}, {31'd0, m_chg});
      chk("R8 done", {31'd0, done}, {31'd0, m_done});
      if (done) done_cnt++;
      if (chg) chg_cnt++;
    end
  end

  task automatic resolve(input bit use_event);
    int d0;
    d0 = done_cnt;
    @(posedge clk); #1;
    if (use_event) ev = 1'b1; else st = 1'b1;
    @(posedge clk); #1;
    st = 1'b0; ev = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_cnt != d0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ab(input logic [15:0] a, input logic [15:0] p);
    phy_regs[4] = a;
    phy_regs[5] = p;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d0, c0, l0;
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk("R6 speed after reset", speed, W10);
    chk("R6 duplex after reset", {31'd0, fdx}, 32'd0);
    chk("R6 no request", {31'd0, req}, 32'd0);
    chk("R6 no pulses", {30'd0, chg, done}, 32'd0);

    // R2 100 full
    c0 = chg_cnt;
    set_ab(16'h01E1, 16'h01E1);
    resolve(0);
    chk("R2 100 full speed", speed, W100);
    chk("R2 100 full duplex", {31'd0, fdx}, 32'd1);
    chk("R5 change counted", chg_cnt - c0, 32'd1);

    // R5 same result, no change
    c0 = chg_cnt; d0 = done_cnt;
    resolve(0);
    chk("R5 no change on same result", chg_cnt - c0, 32'd0);
    chk("R8 done on repeat", done_cnt - d0, 32'd1);

    // R2 100 half through AND
    set_ab(16'h01E1, 16'h00A1);
    resolve(0);
    chk("R2 100 half speed", speed, W100);
    chk("R2 100 half duplex", {31'd0, fdx}, 32'd0);

    // R2 10 full: partner offers 100 but local does not
    set_ab(16'h0061, 16'h01C1);
    resolve(1);
    chk("R2 10 full speed", speed, W10);
    chk("R2 10 full duplex", {31'd0, fdx}, 32'd1);

    // R2 10 half
    set_ab(16'h0021, 16'h0021);
    resolve(0);
    chk("R2 10 half duplex", {31'd0, fdx}, 32'd0);

    // R3 fallback from 100 full
    set_ab(16'h01E1, 16'h01E1);
    resolve(0);
    c0 = chg_cnt;
    set_ab(16'h0101, 16'h0081);
    resolve(0);
    chk("R3 fallback speed", speed, W10);
    chk("R3 fallback duplex", {31'd0, fdx}, 32'd0);
    chk("R3 fallback change", chg_cnt - c0, 32'd1);

    // R7 error on first read
    set_ab(16'h01E1, 16'h01E1);
    err_reg = 4;
    d0 = done_cnt; c0 = chg_cnt; l0 = lpa_acks;
    resolve(0);
    chk("R7 first read error keeps speed", speed, W10);
    chk("R7 no second read", lpa_acks - l0, 32'd0);
    chk("R7 done after error", done_cnt - d0, 32'd1);
    chk("R7 no change", chg_cnt - c0, 32'd0);

    // R7 error on second read
    err_reg = 5;
    d0 = done_cnt; c0 = chg_cnt;
    resolve(1);
    chk("R7 second read error keeps duplex", {31'd0, fdx}, 32'd0);
    chk("R7 done after second error", done_cnt - d0, 32'd1);
    chk("R7 no change second", chg_cnt - c0, 32'd0);
    err_reg = -1;

    // R9 triggers while busy are ignored
    d0 = done_cnt;
    @(posedge clk); #1 st = 1'b1;
    @(posedge clk); #1 st = 1'b0;
    repeat (2) @(posedge clk);
    #1 ev = 1'b1;
    @(posedge clk); #1 ev = 1'b0; st = 1'b1;
    @(posedge clk); #1 st = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 single done for busy triggers", done_cnt - d0, 32'd1);
    chk("R9 result applied", speed, W100);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule